// File: doc/BRIEF.md
# Fifth-Order CIC Decimator for PDM Microphones

This block converts one or two single-bit pulse-density streams into signed multi-bit samples at a lower rate. Each stream passes through five cascaded integrators that run at the input bit rate. A programmable decimation counter picks every M-th integrator value. Five comb (differencing) stages then restore a band-limited sample, and an arithmetic right shift brings the result down to the input width of a following FIR stage. The gain at DC is M to the fifth power.

Both channels have their own integrator chains. The comb stages and the shifter form a single datapath that the two channels share in time. At every decimation point the left sample is processed in the first cycle and the right sample in the next. In mono mode only the left channel runs. Control inputs set the decimation factor, the shift, a per-channel polarity inversion, an output mute, a soft reset that clears the filter state, and a per-channel start.

Top module: `pdm_cic5_decim`

## Requirements
- R1: After `rst_n` is low, and while `soft_rst` is high, `out_vld` is 0. After `rst_n`, `out_data` is 0. A soft reset clears all integrator, comb and counter state.
- R2: With a constant input and `pdm_vld` high on every cycle, the left output settles to M^5 shifted right by the effective shift. Left samples appear exactly once every M strobes.
- R3: `comb_cnt` holds M-1. Values below 4 act as M=5 and values above 30 act as M=31.
- R4: The effective right shift is `shift_code` minus 8. Codes below 8 give no shift. The result is an arithmetic shift truncated to `OUT_W` bits.
- R5: A high `pol_a` (or `pol_b`) inverts that channel's PDM bit before integration, which negates its output.
- R6: When `mute` is high, each emitted sample carries `out_data` = 0. `out_vld` keeps its normal cadence and the filter state is not disturbed.
- R7: In stereo mode with both channels started, the left sample (`out_chan`=0) is emitted in one cycle and the right sample (`out_chan`=1) in the following cycle.
- R8: In mono mode (`stereo`=0) no right sample is ever emitted, and `pdm_b` has no effect on the left output.
- R9: A channel whose start input is low emits no samples. Its integrators are held at zero.
- R10: A PDM bit of 1 counts as +1 and a bit of 0 counts as -1. An all-zero stream gives -(M^5) before the shift, and the integrators wrap in two's complement.
- R11: An alternating 1/0 stream with an even M settles to an output of exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pdm_vld | input | 1 | Strobe: one PDM bit per channel is present |
| pdm_a | input | 1 | Left channel PDM bit |
| pdm_b | input | 1 | Right channel PDM bit |
| comb_cnt | input | CNT_W | Decimation factor minus one |
| shift_code | input | SH_W | Right shift plus 8 |
| pol_a | input | 1 | Invert left PDM bit |
| pol_b | input | 1 | Invert right PDM bit |
| mute | input | 1 | Force emitted samples to zero |
| stereo | input | 1 | 1: both channels, 0: left only |
| soft_rst | input | 1 | Clear filter state, suppress output |
| start_a | input | 1 | Enable left channel |
| start_b | input | 1 | Enable right channel |
| out_vld | output | 1 | Output sample valid |
| out_chan | output | 1 | 0 = left sample, 1 = right sample |
| out_data | output | OUT_W | Signed decimated sample |

## Verification
The filter is driven with all-ones, all-zeros and alternating streams. All-ones gives the positive gain, all-zeros shows the -1 mapping, and alternating with an even M shows the zero at half the input rate. Both polarity settings are applied, which tells inversion apart from the bit mapping. Three decimation factors are used: the smallest, a middle one and the largest, including out-of-range fields. Each is run with shift codes below, at and above the bias, so that the output value and the sample period confirm both the count and the shift. Stereo runs feed the two channels opposite streams, so that each slot can be traced to its channel. Mono and unstarted runs watch the outputs for samples that must not appear.

// File: rtl/cic5_pkg.sv
// Shared constants and types of the fifth-order CIC decimator.
// Assumes: nothing beyond IEEE 1800-2017.
package cic5_pkg;
    localparam int unsigned CIC_ORDER  = 5;
    localparam int unsigned SHIFT_BIAS = 8;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_LEFT  = 2'd1,
        SLOT_RIGHT = 2'd2
    } slot_t;
endpackage

// File: rtl/cic5_integrators.sv
// Five cascaded integrators for one PDM channel.
// Each stage adds the registered value of the stage before it, so all stages
// update in the same cycle. Wraps in two's complement, which the combs undo.
// Assumes: ACC_W covers the full bit growth of M^5 plus a sign bit.
module cic5_integrators
    import cic5_pkg::*;
#(
    parameter int ACC_W = 26
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    step,
    input  logic                    bit_in,
    input  logic                    invert,
    output logic signed [ACC_W-1:0] acc_out
);
    logic signed [ACC_W-1:0] acc [CIC_ORDER];
    logic signed [ACC_W-1:0] unit;

    // Map the (optionally inverted) bit onto +1 or -1.
    assign unit = (bit_in ^ invert) ? ACC_W'(1) : {ACC_W{1'b1}};

    // Advance the integrator cascade on each strobe; clear on reset or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int k = 0; k < CIC_ORDER; k++) acc[k] <= '0;
        end else if (step) begin
            acc[0] <= acc[0] + unit;
            for (int k = 1; k < CIC_ORDER; k++) acc[k] <= acc[k] + acc[k-1];
        end
    end

    assign acc_out = acc[CIC_ORDER-1];
endmodule

// File: rtl/cic5_combs.sv
// Five comb stages shared by two channels.
// The selected channel's delay elements are used and updated. The chain is
// combinational from x_in to y_out.
// Assumes: at most one channel is processed per cycle.
module cic5_combs
    import cic5_pkg::*;
#(
    parameter int ACC_W = 26
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    upd,
    input  logic                    sel,
    input  logic signed [ACC_W-1:0] x_in,
    output logic signed [ACC_W-1:0] y_out
);
    logic signed [ACC_W-1:0] dly_l [CIC_ORDER];
    logic signed [ACC_W-1:0] dly_r [CIC_ORDER];
    logic signed [ACC_W-1:0] stg   [CIC_ORDER+1];

    // Difference chain against the selected channel's delays.
    always_comb begin
        stg[0] = x_in;
        for (int k = 0; k < CIC_ORDER; k++)
            stg[k+1] = stg[k] - (sel ? dly_r[k] : dly_l[k]);
    end

    // Store each stage input as the next delay of the selected channel.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int k = 0; k < CIC_ORDER; k++) begin
                dly_l[k] <= '0;
                dly_r[k] <= '0;
            end
        end else if (upd) begin
            for (int k = 0; k < CIC_ORDER; k++) begin
                if (sel) dly_r[k] <= stg[k];
                else     dly_l[k] <= stg[k];
            end
        end
    end

    assign y_out = stg[CIC_ORDER];
endmodule

// File: rtl/cic5_shift.sv
// Biased arithmetic right shift with truncation to the FIR input width.
// Codes below the bias give no shift.
// Assumes: OUT_W <= ACC_W and SH_W can hold the bias.
module cic5_shift
    import cic5_pkg::*;
#(
    parameter int ACC_W = 26,
    parameter int OUT_W = 22,
    parameter int SH_W  = 4
) (
    input  logic [SH_W-1:0]         code,
    input  logic signed [ACC_W-1:0] din,
    output logic signed [OUT_W-1:0] dout
);
    localparam logic [SH_W-1:0] BIAS = SH_W'(SHIFT_BIAS);

    logic [SH_W-1:0]         amt;
    logic signed [ACC_W-1:0] shifted;

    // Remove the bias, floor at zero, then shift and keep the low bits.
    always_comb begin
        amt     = (code >= BIAS) ? code - BIAS : '0;
        shifted = din >>> amt;
        dout    = shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/pdm_cic5_decim.sv
// Two-channel fifth-order CIC decimator top.
// Each channel has its own integrators. One comb/shift path processes the
// left sample in the cycle after a decimation point and the right sample in
// the cycle after that.
// Assumes: decimation points are at least three cycles apart (M >= M_MIN >= 3).
module pdm_cic5_decim
    import cic5_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int SH_W  = 4,
    parameter int OUT_W = 22,
    parameter int M_MIN = 5,
    parameter int M_MAX = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pdm_vld,
    input  logic             pdm_a,
    input  logic             pdm_b,
    input  logic [CNT_W-1:0] comb_cnt,
    input  logic [SH_W-1:0]  shift_code,
    input  logic             pol_a,
    input  logic             pol_b,
    input  logic             mute,
    input  logic             stereo,
    input  logic             soft_rst,
    input  logic             start_a,
    input  logic             start_b,
    output logic             out_vld,
    output logic             out_chan,
    output logic [OUT_W-1:0] out_data
);
    localparam int ACC_W = 1 + CIC_ORDER * $clog2(M_MAX);
    localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(M_MIN - 1);
    localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(M_MAX - 1);

    logic [CNT_W-1:0]        lim;
    logic [CNT_W-1:0]        cnt;
    logic                    tick;
    slot_t                   slot;
    logic                    bits [2];
    logic                    inv  [2];
    logic                    clr  [2];
    logic signed [ACC_W-1:0] acc  [2];
    logic signed [ACC_W-1:0] snap [2];
    logic                    sel;
    logic                    upd;
    logic signed [ACC_W-1:0] comb_y;
    logic signed [OUT_W-1:0] shaped;

    // Clamp the programmed count to the supported decimation range.
    always_comb begin
        if (comb_cnt < LIM_LO)      lim = LIM_LO;
        else if (comb_cnt > LIM_HI) lim = LIM_HI;
        else                        lim = comb_cnt;
    end

    assign tick = pdm_vld && (cnt >= lim);

    // Count strobes and wrap at the decimation point.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) cnt <= '0;
        else if (pdm_vld)       cnt <= tick ? '0 : cnt + CNT_W'(1);
    end

    // Per-channel inputs: the right chain is held clear unless stereo runs.
    assign bits[0] = pdm_a;
    assign bits[1] = pdm_b;
    assign inv[0]  = pol_a;
    assign inv[1]  = pol_b;
    assign clr[0]  = soft_rst || !start_a;
    assign clr[1]  = soft_rst || !start_b || !stereo;

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        cic5_integrators #(.ACC_W(ACC_W)) u_integ (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr[ch]),
            .step    (pdm_vld),
            .bit_in  (bits[ch]),
            .invert  (inv[ch]),
            .acc_out (acc[ch])
        );

        // Capture the integrator output at each decimation point.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) snap[ch] <= '0;
            else if (tick)          snap[ch] <= acc[ch];
        end
    end

    // Sequence the shared comb path: left slot, then right slot.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) slot <= SLOT_IDLE;
        else if (tick)          slot <= SLOT_LEFT;
        else if (slot == SLOT_LEFT) slot <= SLOT_RIGHT;
        else                    slot <= SLOT_IDLE;
    end

    assign sel = (slot == SLOT_RIGHT);
    assign upd = ((slot == SLOT_LEFT) && start_a)
              || ((slot == SLOT_RIGHT) && start_b && stereo);

    cic5_combs #(.ACC_W(ACC_W)) u_combs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .upd   (upd),
        .sel   (sel),
        .x_in  (sel ? snap[1] : snap[0]),
        .y_out (comb_y)
    );

    cic5_shift #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_shift (
        .code (shift_code),
        .din  (comb_y),
        .dout (shaped)
    );

    // Register the emitted sample, applying mute to the data only.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            out_vld  <= 1'b0;
            out_chan <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= upd;
            if (upd) begin
                out_chan <= sel;
                out_data <= mute ? '0 : shaped;
            end
        end
    end
endmodule

// File: rtl/cic5_decim_chk.sv
// Temporal checks on the decimator's ports, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module cic5_decim_chk #(
    parameter int OUT_W = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             mute,
    input logic             stereo,
    input logic             start_a,
    input logic             start_b,
    input logic             out_vld,
    input logic             out_chan,
    input logic [OUT_W-1:0] out_data
);
    // R1
    soft_reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !out_vld);

    // R6
    mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(mute)) |-> (out_data == '0));

    // R8
    right_needs_stereo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_chan) |-> $past(stereo && start_b));

    // R9
    left_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_chan) |-> $past(start_a));

    // R2
    left_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_chan) |=> !(out_vld && !out_chan));

    // R7
    right_after_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_chan && $past(start_a)) |-> $past(out_vld && !out_chan));
endmodule

bind pdm_cic5_decim cic5_decim_chk #(.OUT_W(OUT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .mute     (mute),
    .stereo   (stereo),
    .start_a  (start_a),
    .start_b  (start_b),
    .out_vld  (out_vld),
    .out_chan (out_chan),
    .out_data (out_data)
);

// File: tb/sim_pdm_cic5_decim.sv
module sim_pdm_cic5_decim;
    localparam int CNT_W = 5;
    localparam int SH_W  = 4;
    localparam int OUT_W = 22;
    localparam int NV    = 10;
    localparam int CAP   = 4000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n, pdm_vld, pdm_a, pdm_b;
    logic [CNT_W-1:0] comb_cnt;
    logic [SH_W-1:0]  shift_code;
    logic             pol_a, pol_b, mute, stereo, soft_rst, start_a, start_b;
    logic             out_vld, out_chan;
    logic [OUT_W-1:0] out_data;

    pdm_cic5_decim #(.CNT_W(CNT_W), .SH_W(SH_W), .OUT_W(OUT_W)) u0 (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int pat_a, pat_b;
    bit ph;
    bit ovld, ochan;
    int odata;

    // Columns: comb_cnt, shift_code, pattern (0 zeros, 1 ones, 2 alternate), pol, M, expected
    localparam int TV [NV][6] = '{
        '{ 7,  8, 1, 0,  8,    32768},  // R2 R10
        '{ 7, 11, 1, 0,  8,     4096},  // R4
        '{ 7,  3, 1, 0,  8,    32768},  // R4 below bias
        '{ 7,  8, 0, 0,  8,   -32768},  // R10
        '{ 7,  8, 1, 1,  8,   -32768},  // R5
        '{ 7,  8, 2, 0,  8,        0},  // R11
        '{ 2,  8, 1, 0,  5,     3125},  // R3 low clamp
        '{31, 12, 1, 0, 31,  1789321},  // R3 high clamp
        '{31, 12, 0, 0, 31, -1789322},  // R3 R10 negative floor
        '{19, 10, 1, 0, 20,   800000}   // R2 mid factor
    };
    string tags [NV] = '{"R2", "R4", "R4", "R10", "R5", "R11", "R3", "R3", "R10", "R2"};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pbit(input int pat, input bit p);
        return (pat == 2) ? logic'(p) : logic'(pat == 1);
    endfunction

    // One cycle: sample outputs at the falling edge, then drive the next bits.
    task automatic step();
        @(negedge clk);
        ovld  = out_vld;
        ochan = out_chan;
        odata = int'($signed(out_data));
        ph    = ~ph;
        pdm_a = pbit(pat_a, ph);
        pdm_b = pbit(pat_b, ph);
    endtask

    task automatic do_soft_reset();
        soft_rst = 1'b1;
        for (int i = 0; i < 3; i++) step();
        soft_rst = 1'b0;
    endtask

    // Wait for the n-th left sample; report its value and the gap before it.
    task automatic wait_left(input int n, output int val, output int gap);
        int seen = 0;
        int since = 0;
        val = 0;
        gap = -1;
        for (int c = 0; c < CAP && seen < n; c++) begin
            step();
            since++;
            if (ovld && !ochan) begin
                seen++;
                val = odata;
                gap = since;
                since = 0;
            end
        end
        if (seen < n) check("R2 timeout", seen, n);
    endtask

    initial begin
        int v, g, cnt_r, cnt_any;
        rst_n = 0; pdm_vld = 1; pdm_a = 0; pdm_b = 0; comb_cnt = 7; shift_code = 8;
        pol_a = 0; pol_b = 0; mute = 0; stereo = 0; soft_rst = 0;
        start_a = 1; start_b = 0; pat_a = 1; pat_b = 1; ph = 0;
        for (int i = 0; i < 4; i++) step();
        check("R1 reset vld", int'(ovld), 0);
        check("R1 reset data", odata, 0);
        rst_n = 1;

        // Table walk: settled value and sample period for each vector.
        for (int i = 0; i < NV; i++) begin
            comb_cnt = CNT_W'(TV[i][0]);
            shift_code = SH_W'(TV[i][1]);
            pat_a = TV[i][2];
            pat_b = TV[i][2];
            pol_a = TV[i][3] != 0;
            do_soft_reset();
            wait_left(8, v, g);
            check(tags[i], v, TV[i][5]);
            check("R3 period", g, TV[i][4]);
        end
        pol_a = 0;

        // R1: soft reset during activity suppresses output.
        comb_cnt = 4; pat_a = 1;
        cnt_any = 0;
        soft_rst = 1'b1;
        for (int i = 0; i < 20; i++) begin step(); if (ovld) cnt_any++; end
        soft_rst = 1'b0;
        check("R1 soft reset", cnt_any, 0);

        // R6: mute zeroes data, keeps cadence and state.
        comb_cnt = 7; shift_code = 8; do_soft_reset();
        wait_left(8, v, g);
        mute = 1;
        wait_left(1, v, g);
        check("R6 muted", v, 0);
        check("R6 cadence", g, 8);
        mute = 0;
        wait_left(2, v, g);
        check("R6 unmuted", v, 32768);

        // R7: stereo, left ones and right zeros.
        stereo = 1; start_b = 1; pat_a = 1; pat_b = 0; do_soft_reset();
        wait_left(8, v, g);
        check("R7 left", v, 32768);
        step();
        check("R7 right slot", int'(ovld && ochan), 1);
        check("R7 right value", odata, -32768);

        // R8: mono ignores the right stream.
        stereo = 0; pat_b = 2; do_soft_reset();
        cnt_r = 0;
        for (int i = 0; i < 200; i++) begin step(); if (ovld && ochan) cnt_r++; end
        check("R8 no right", cnt_r, 0);
        wait_left(1, v, g);
        check("R8 left value", v, 32768);

        // R9: unstarted left channel stays silent.
        start_a = 0; start_b = 0; do_soft_reset();
        cnt_any = 0;
        for (int i = 0; i < 200; i++) begin step(); if (ovld) cnt_any++; end
        check("R9 silent", cnt_any, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule